// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block turns a six-byte window, fetched at the current program counter, into the fields that later stages of a small processor need. The first byte carries a 4-bit instruction class and a 4-bit variant selector. From that byte alone the block decides how many bytes the instruction occupies. It also decides whether a register-pair byte follows, and whether a 32-bit constant is present and where it sits.

The block is purely combinational. The fetch logic feeds it the window and the PC, and in the same cycle it receives the decoded class, the variant, both register identifiers, the constant and the address of the following instruction. An unknown class, or a variant that the class does not define, raises an invalid flag. When that flag is raised, the decoded fields collapse to safe defaults, so that a trap handler sees a predictable state.

Top module: `instr_len_decoder`

## Requirements
- R1: The window packs byte k at bits [8k+7:8k]. For byte 0, bits [7:4] are driven on `icode` and bits [3:0] on `ifun`, whether or not the instruction is valid.
- R2: The decoded length is 1 for class 0 (no-op), class 1 (stop) and class 9 (return). It is 2 for class 2 (register move), class 6 (ALU op), class 0xA (push) and class 0xB (pop). It is 5 for class 7 (branch) and class 8 (subroutine call). It is 6 for class 3 (immediate load), class 4 (store) and class 5 (load).
- R3: `next_pc` equals `pc` plus the decoded length, modulo 2^32.
- R4: Classes 2, 3, 4, 5, 6, 0xA and 0xB drive byte 1 bits [7:4] on `ra` and byte 1 bits [3:0] on `rb`. All other classes drive 8 (no register) on both.
- R5: Classes 3, 4 and 5 take the constant little-endian from bytes 2..5, with byte 2 as the least significant byte.
- R6: Classes 7 and 8 take the constant little-endian from bytes 1..4, as an absolute target address.
- R7: Classes 0, 1, 2, 6, 9, 0xA and 0xB output a constant of 0.
- R8: A class code of 0xC to 0xF raises `bad_instr`. An invalid instruction reports length 1, `ra` = `rb` = 8 and constant 0.
- R9: `bad_instr` is raised when the variant field is out of range for its class. Class 6 accepts 0..3, class 7 accepts 0..6, and every other defined class accepts only 0.
- R10: The window 30 82 cd ab 00 00 yields `rb` = 2 and a constant of 0x0000abcd. The window 50 15 f4 ff ff ff yields `ra` = 1, `rb` = 5 and a constant of 0xfffffff4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_win | input | 48 | Six instruction bytes, byte 0 in the low bits |
| pc | input | 32 | Address of byte 0 |
| icode | output | 4 | Instruction class (byte 0 high nibble) |
| ifun | output | 4 | Variant selector (byte 0 low nibble) |
| ra | output | 4 | First register identifier, 8 if none |
| rb | output | 4 | Second register identifier, 8 if none |
| valc | output | 32 | Decoded constant, 0 if none |
| ilen | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Address of the following instruction |
| bad_instr | output | 1 | Invalid class or variant |

## Verification
Invalid-code detection and length/constant extraction fall on the same window. An invalid variant under a long class must override the length, register and constant that the class alone would produce. The bench provokes this with ALU op variant 4, branch variant 7 and non-zero variants on single-variant classes, filling the trailing bytes with non-zero data. A pass requires length 1, registers 8, constant 0, `next_pc` at `pc`+1 and the flag raised, all on the same window. A second overlap is PC wrap combined with a six-byte instruction near the top of the address space.

// File: rtl/idec_pkg.sv
// Package: shared widths and class codes for the instruction byte decoder.
// Assumes a 32-bit constant and a one-byte register-pair field.
package idec_pkg;
    localparam int WORD_W      = 32;
    localparam int CONST_BYTES = WORD_W / 8;
    localparam int WIN_BYTES   = 2 + CONST_BYTES;
    localparam int WIN_W       = WIN_BYTES * 8;
    localparam int LEN_W       = $clog2(WIN_BYTES + 1);
    localparam logic [3:0] NO_REG = 4'h8;

    localparam logic [3:0] C_NOP   = 4'h0;
    localparam logic [3:0] C_STOP  = 4'h1;
    localparam logic [3:0] C_RMOV  = 4'h2;
    localparam logic [3:0] C_IMOV  = 4'h3;
    localparam logic [3:0] C_STORE = 4'h4;
    localparam logic [3:0] C_LOAD  = 4'h5;
    localparam logic [3:0] C_ALU   = 4'h6;
    localparam logic [3:0] C_BR    = 4'h7;
    localparam logic [3:0] C_CALL  = 4'h8;
    localparam logic [3:0] C_RET   = 4'h9;
    localparam logic [3:0] C_PUSH  = 4'hA;
    localparam logic [3:0] C_POP   = 4'hB;

    localparam logic [3:0] ALU_MAX = 4'h3;
    localparam logic [3:0] BR_MAX  = 4'h6;

    // Shape of an instruction as seen by the byte extractors.
    typedef struct packed {
        logic             ok;
        logic             has_reg;
        logic             has_const;
        logic [LEN_W-1:0] len;
    } ishape_t;
endpackage

// File: rtl/idec_split.sv
// Module: idec_split
// Cuts the fetch window into bytes and the first byte into class and variant.
// Assumes byte k of the window occupies bits [8k+7:8k].
module idec_split
    import idec_pkg::*;
#(
    parameter int NB = WIN_BYTES
) (
    input  logic [NB*8-1:0]     win_i,
    output logic [NB-1:0][7:0]  bytes_o,
    output logic [3:0]          cls_o,
    output logic [3:0]          var_o
);
    // Byte slicing, one slice per window byte.
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign bytes_o[k] = win_i[8*k +: 8];
    end

    // Opcode byte nibble split.
    always_comb begin
        cls_o = bytes_o[0][7:4];
        var_o = bytes_o[0][3:0];
    end
endmodule

// File: rtl/idec_classify.sv
// Module: idec_classify
// Maps class and variant to validity, field presence and length.
// Assumes invalid codes are reported as one-byte instructions with no fields.
module idec_classify
    import idec_pkg::*;
(
    input  logic [3:0] cls_i,
    input  logic [3:0] var_i,
    output ishape_t    shape_o
);
    logic var_ok;

    // Variant range check per class.
    always_comb begin
        unique case (cls_i)
            C_ALU:   var_ok = (var_i <= ALU_MAX);
            C_BR:    var_ok = (var_i <= BR_MAX);
            default: var_ok = (var_i == 4'h0);
        endcase
    end

    // Shape lookup; unknown classes and bad variants collapse to length 1.
    always_comb begin
        shape_o = '{ok: 1'b0, has_reg: 1'b0, has_const: 1'b0, len: LEN_W'(1)};
        if (var_ok) begin
            unique case (cls_i)
                C_NOP, C_STOP, C_RET: begin
                    shape_o.ok  = 1'b1;
                    shape_o.len = LEN_W'(1);
                end
                C_RMOV, C_ALU, C_PUSH, C_POP: begin
                    shape_o.ok      = 1'b1;
                    shape_o.has_reg = 1'b1;
                    shape_o.len     = LEN_W'(2);
                end
                C_BR, C_CALL: begin
                    shape_o.ok        = 1'b1;
                    shape_o.has_const = 1'b1;
                    shape_o.len       = LEN_W'(1 + CONST_BYTES);
                end
                C_IMOV, C_STORE, C_LOAD: begin
                    shape_o.ok        = 1'b1;
                    shape_o.has_reg   = 1'b1;
                    shape_o.has_const = 1'b1;
                    shape_o.len       = LEN_W'(2 + CONST_BYTES);
                end
                default: shape_o.ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/idec_fields.sv
// Module: idec_fields
// Extracts register identifiers and the little-endian constant.
// Assumes the constant starts at byte 2 when a register byte exists, else byte 1.
module idec_fields
    import idec_pkg::*;
(
    input  logic [WIN_BYTES-1:0][7:0] bytes_i,
    input  ishape_t                   shape_i,
    output logic [3:0]                ra_o,
    output logic [3:0]                rb_o,
    output logic [WORD_W-1:0]         valc_o
);
    logic [WORD_W-1:0] after_reg;
    logic [WORD_W-1:0] after_op;

    // Two candidate constant alignments, byte by byte.
    for (genvar j = 0; j < CONST_BYTES; j++) begin : g_cbyte
        assign after_reg[8*j +: 8] = bytes_i[2 + j];
        assign after_op[8*j +: 8]  = bytes_i[1 + j];
    end

    // Register identifiers, defaulting to the no-register code.
    always_comb begin
        if (shape_i.has_reg) begin
            ra_o = bytes_i[1][7:4];
            rb_o = bytes_i[1][3:0];
        end else begin
            ra_o = NO_REG;
            rb_o = NO_REG;
        end
    end

    // Constant selection by alignment, zero when absent.
    always_comb begin
        if (!shape_i.has_const)     valc_o = '0;
        else if (shape_i.has_reg)   valc_o = after_reg;
        else                        valc_o = after_op;
    end
endmodule

// File: rtl/instr_len_decoder.sv
// Module: instr_len_decoder
// Top of the combinational instruction byte decoder: fields, length, next PC.
// Assumes the window was fetched at pc; no state, no clock.
module instr_len_decoder
    import idec_pkg::*;
(
    input  logic [47:0] fetch_win,
    input  logic [31:0] pc,
    output logic [3:0]  icode,
    output logic [3:0]  ifun,
    output logic [3:0]  ra,
    output logic [3:0]  rb,
    output logic [31:0] valc,
    output logic [2:0]  ilen,
    output logic [31:0] next_pc,
    output logic        bad_instr
);
    logic [WIN_BYTES-1:0][7:0] win_bytes;
    ishape_t                   shape;

    idec_split #(.NB(WIN_BYTES)) u_split (
        .win_i   (fetch_win),
        .bytes_o (win_bytes),
        .cls_o   (icode),
        .var_o   (ifun)
    );

    idec_classify u_class (
        .cls_i   (icode),
        .var_i   (ifun),
        .shape_o (shape)
    );

    idec_fields u_fields (
        .bytes_i (win_bytes),
        .shape_i (shape),
        .ra_o    (ra),
        .rb_o    (rb),
        .valc_o  (valc)
    );

    // Length, flag and sequential successor address.
    always_comb begin
        ilen      = shape.len;
        bad_instr = !shape.ok;
        next_pc   = pc + {{(WORD_W-LEN_W){1'b0}}, shape.len};
    end
endmodule

// File: rtl/instr_len_decoder_chk.sv
// Module: instr_len_decoder_chk
// Output-consistency checks for the decoder, attached by bind.
// Assumes outputs are sampled once inputs are known.
module instr_len_decoder_chk (
    input logic [31:0] pc,
    input logic [3:0]  icode,
    input logic [3:0]  ra,
    input logic [3:0]  rb,
    input logic [31:0] valc,
    input logic [2:0]  ilen,
    input logic [31:0] next_pc,
    input logic        bad_instr
);
    // Relations among the decoded outputs.
    always_comb begin
        if (!$isunknown({pc, icode, ilen, next_pc, bad_instr, ra, rb, valc})) begin
            AST_LEN_LEGAL: assert (ilen == 3'd1 || ilen == 3'd2 || ilen == 3'd5 || ilen == 3'd6); // R2
            AST_NEXT_PC: assert (next_pc - pc == {29'd0, ilen}); // R3
            AST_NOREG_SHORT: assert (!(ilen == 3'd1 || ilen == 3'd5) || (ra == 4'h8 && rb == 4'h8)); // R4
            AST_CONST_ABSENT: assert (!(ilen <= 3'd2) || valc == 32'd0); // R7
            AST_BAD_SAFE: assert (!bad_instr || (ilen == 3'd1 && ra == 4'h8 && valc == 32'd0)); // R8
            AST_HIGH_CLASS: assert (icode < 4'hC || bad_instr); // R8
        end
    end
endmodule

bind instr_len_decoder instr_len_decoder_chk u_chk (
    .pc        (pc),
    .icode     (icode),
    .ra        (ra),
    .rb        (rb),
    .valc      (valc),
    .ilen      (ilen),
    .next_pc   (next_pc),
    .bad_instr (bad_instr)
);

// File: tb/instr_len_decoder_bench.sv
// Directed bench for the instruction byte decoder; one task per scenario.
module instr_len_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] fetch_win = '0;
    logic [31:0] pc = '0;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, next_pc;
    logic [2:0]  ilen;
    logic        bad_instr;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    instr_len_decoder u_instr_len_decoder (
        .fetch_win (fetch_win),
        .pc        (pc),
        .icode     (icode),
        .ifun      (ifun),
        .ra        (ra),
        .rb        (rb),
        .valc      (valc),
        .ilen      (ilen),
        .next_pc   (next_pc),
        .bad_instr (bad_instr)
    );

    function automatic logic [47:0] pack6(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // Apply a window at a falling edge and let it settle before sampling.
    task automatic apply(input logic [47:0] w, input logic [31:0] p);
        @(negedge clk);
        fetch_win = w;
        pc = p;
        #2;
    endtask

    // Full field comparison for one window.
    task automatic expect_all(input string req, input logic [3:0] ic, input logic [3:0] fn,
                              input logic [3:0] era, input logic [3:0] erb, input logic [31:0] ec,
                              input logic [2:0] el, input logic [31:0] enpc, input logic eb);
        chk(req, "icode", {28'd0, icode}, {28'd0, ic});
        chk(req, "ifun", {28'd0, ifun}, {28'd0, fn});
        chk(req, "ra", {28'd0, ra}, {28'd0, era});
        chk(req, "rb", {28'd0, rb}, {28'd0, erb});
        chk(req, "valc", valc, ec);
        chk(req, "ilen", {29'd0, ilen}, {29'd0, el});
        chk(req, "next_pc", next_pc, enpc);
        chk(req, "bad", {31'd0, bad_instr}, {31'd0, eb});
    endtask

    task automatic t_reset_state;
        apply('0, 32'h0);
        expect_all("R1_reset", 4'h0, 4'h0, 4'h8, 4'h8, 32'd0, 3'd1, 32'h1, 1'b0);
    endtask

    task automatic t_one_byte;
        apply(pack6(8'h10, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff), 32'h100);
        expect_all("R2_stop", 4'h1, 4'h0, 4'h8, 4'h8, 32'd0, 3'd1, 32'h101, 1'b0);
        apply(pack6(8'h90, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a), 32'h200);
        expect_all("R7_ret", 4'h9, 4'h0, 4'h8, 4'h8, 32'd0, 3'd1, 32'h201, 1'b0);
    endtask

    task automatic t_reg_byte;
        apply(pack6(8'h20, 8'h43, 8'hee, 8'hee, 8'hee, 8'hee), 32'h40);
        expect_all("R4_rmov", 4'h2, 4'h0, 4'h4, 4'h3, 32'd0, 3'd2, 32'h42, 1'b0);
        for (int f = 0; f < 4; f++) begin
            apply(pack6({4'h6, 4'(f)}, 8'h06, 8'h11, 8'h22, 8'h33, 8'h44), 32'h10);
            expect_all("R2_alu", 4'h6, 4'(f), 4'h0, 4'h6, 32'd0, 3'd2, 32'h12, 1'b0);
        end
        apply(pack6(8'hA0, 8'h28, 8'h55, 8'h55, 8'h55, 8'h55), 32'h8);
        expect_all("R4_push", 4'hA, 4'h0, 4'h2, 4'h8, 32'd0, 3'd2, 32'hA, 1'b0);
        apply(pack6(8'hB0, 8'h38, 8'h55, 8'h55, 8'h55, 8'h55), 32'h8);
        expect_all("R4_pop", 4'hB, 4'h0, 4'h3, 4'h8, 32'd0, 3'd2, 32'hA, 1'b0);
    endtask

    task automatic t_const_after_reg;
        apply(pack6(8'h30, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00), 32'h0);
        expect_all("R10_imm", 4'h3, 4'h0, 4'h8, 4'h2, 32'h0000abcd, 3'd6, 32'h6, 1'b0);
        apply(pack6(8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff), 32'h20);
        expect_all("R10_load", 4'h5, 4'h0, 4'h1, 4'h5, 32'hfffffff4, 3'd6, 32'h26, 1'b0);
        apply(pack6(8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00), 32'h30);
        expect_all("R5_store", 4'h4, 4'h0, 4'h6, 4'h4, 32'h0000041c, 3'd6, 32'h36, 1'b0);
    endtask

    task automatic t_const_after_op;
        for (int f = 0; f < 7; f++) begin
            apply(pack6({4'h7, 4'(f)}, 8'h78, 8'h56, 8'h34, 8'h12, 8'hcc), 32'h1000);
            expect_all("R6_branch", 4'h7, 4'(f), 4'h8, 4'h8, 32'h12345678, 3'd5, 32'h1005, 1'b0);
        end
        apply(pack6(8'h80, 8'h28, 8'h00, 8'h00, 8'h00, 8'hff), 32'h10);
        expect_all("R6_call", 4'h8, 4'h0, 4'h8, 4'h8, 32'h00000028, 3'd5, 32'h15, 1'b0);
    endtask

    task automatic t_bad_class;
        for (int c = 12; c < 16; c++) begin
            apply(pack6({4'(c), 4'h0}, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a), 32'h50);
            expect_all("R8_class", 4'(c), 4'h0, 4'h8, 4'h8, 32'd0, 3'd1, 32'h51, 1'b1);
        end
    endtask

    task automatic t_bad_variant;
        apply(pack6(8'h64, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a), 32'h60);
        expect_all("R9_alu4", 4'h6, 4'h4, 4'h8, 4'h8, 32'd0, 3'd1, 32'h61, 1'b1);
        apply(pack6(8'h77, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a), 32'h60);
        expect_all("R9_br7", 4'h7, 4'h7, 4'h8, 4'h8, 32'd0, 3'd1, 32'h61, 1'b1);
        apply(pack6(8'h31, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00), 32'h60);
        expect_all("R9_imm1", 4'h3, 4'h1, 4'h8, 4'h8, 32'd0, 3'd1, 32'h61, 1'b1);
        apply(pack6(8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 32'h60);
        expect_all("R9_stop1", 4'h1, 4'h1, 4'h8, 4'h8, 32'd0, 3'd1, 32'h61, 1'b1);
        apply(pack6(8'h8f, 8'h28, 8'h00, 8'h00, 8'h00, 8'h00), 32'h60);
        expect_all("R9_call", 4'h8, 4'hf, 4'h8, 4'h8, 32'd0, 3'd1, 32'h61, 1'b1);
    endtask

    task automatic t_pc_wrap;
        apply(pack6(8'h30, 8'h87, 8'h01, 8'h00, 8'h00, 8'h80), 32'hFFFF_FFFE);
        expect_all("R3_wrap", 4'h3, 4'h0, 4'h8, 4'h7, 32'h80000001, 3'd6, 32'h4, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        if (rst_n) begin
            t_reset_state();
            t_one_byte();
            t_reg_byte();
            t_const_after_reg();
            t_const_after_op();
            t_bad_class();
            t_bad_variant();
            t_pc_wrap();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule